// File: doc/BRIEF.md
# Battery Load-Test Scheduler

This block decides when a backup cell is put under a test load and keeps a sticky low-battery warning. A time-base tick paces every interval. While the supply is good, the block waits a recovery time and then raises a load strobe for a fixed number of ticks. The strobe switches in an external test resistor. During that window a comparator reports whether the loaded cell is below its trip point. A second comparator reports whether no cell is present at all.

With no warning, tests repeat on a long interval. Once a test fails, the active-low warning output is driven low and tests repeat on a short interval. The warning clears in only two cases. The first is the first test after a power-up reading good. The second is a cell that was seen missing for long enough and then reads good, which means it was replaced. While the supply is bad, all timing stops, no load is applied and the warning holds its value. Every duration is a parameter in ticks.

Top module: `batt_load_sched`

## Requirements
- R1: After reset `load_en` is 0 and `warn_n` is 1. While `pwr_ok` is 0, no load strobe is produced.
- R2: After `pwr_ok` rises, `load_en` goes to 1 in the clock that follows the REC_TICKS-th tick. Every new test begins this way after a power-up.
- R3: `load_en` stays at 1 for exactly PULSE_TICKS ticks. It falls in the clock that follows the last of those ticks (the pulse end).
- R4: While no warning is active, each test starts NORM_TICKS ticks after the previous test started.
- R5: A below-trip or missing-cell reading sets the warning (`warn_n` = 0) at the pulse end. The reading may come on any clock in which `load_en` is 1. Comparator inputs on clocks where `load_en` is 0 have no effect.
- R6: While the warning is active, each test starts WARN_TICKS ticks after the previous test started.
- R7: While warned, a good reading clears the warning if two conditions hold: a missing-cell reading came before it, and at least ABSENT_TICKS ticks passed from that earlier pulse end to this one. Otherwise the warning stays. After a clear, the R4 interval applies again.
- R8: When `pwr_ok` falls, `load_en` drops in the next clock and the warning holds its value. The test in progress is discarded and gives no result.
- R9: The first test after each power-up clears an active warning if it reads good. If it reads below trip, the warning stays active.
- R10: A below-trip reading or a good-but-unqualified reading ends any pending absence timing. A later replacement must then be missing for the full ABSENT_TICKS again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock time-base pulse |
| pwr_ok | input | 1 | Main supply within tolerance |
| bat_low | input | 1 | Loaded cell below trip point |
| bat_none | input | 1 | No cell attached |
| load_en | output | 1 | Connect test load to the cell |
| warn_n | output | 1 | Low-battery warning, active low |

## Verification
The hardest case to reach is the replacement clear. The warning must already be set, and a run of missing-cell readings must then be followed by a good one. Whether the clear happens depends on how many short intervals the run covered. The stimulus first forces the warning with a below-trip pulse. It then drives `bat_none` for a chosen number of consecutive tests: one or two as directed boundary cases around ABSENT_TICKS, then seeded random counts. A below-trip reading placed inside an absence run checks that the absence count restarts.

// File: rtl/batt_test_pkg.sv
package batt_test_pkg;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0,
    PH_REC = 2'd1,
    PH_RUN = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    RD_GOOD = 2'd0,
    RD_LOW  = 2'd1,
    RD_NONE = 2'd2
  } reading_t;

endpackage

// File: rtl/bts_timer.sv
module bts_timer
  import batt_test_pkg::*;
#(
  parameter int REC_TICKS   = 5,
  parameter int PULSE_TICKS = 100,
  parameter int NORM_TICKS  = 8640000,
  parameter int WARN_TICKS  = 500,
  parameter int CW          = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_ok,
  input  logic warned,
  output logic load_en,
  output logic pulse_end,
  output logic first_test
);

  localparam logic [CW-1:0] REC_LAST   = CW'(REC_TICKS - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);
  localparam logic [CW-1:0] PULSE_LEN  = CW'(PULSE_TICKS);
  localparam logic [CW-1:0] NORM_LAST  = CW'(NORM_TICKS - 1);
  localparam logic [CW-1:0] WARN_LAST  = CW'(WARN_TICKS - 1);

  phase_t          ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            first_q, first_d;
  logic [CW-1:0]   per_last;

  assign per_last = warned ? WARN_LAST : NORM_LAST;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    case (ph_q)
      PH_OFF: begin
        if (pwr_ok) begin
          ph_d  = PH_REC;
          cnt_d = '0;
        end
      end
      PH_REC: begin
        if (!pwr_ok) begin
          ph_d  = PH_OFF;
          cnt_d = '0;
        end else if (tick) begin
          if (cnt_q == REC_LAST) begin
            ph_d    = PH_RUN;
            cnt_d   = '0;
            first_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_RUN: begin
        if (!pwr_ok) begin
          ph_d    = PH_OFF;
          cnt_d   = '0;
          first_d = 1'b0;
        end else if (tick) begin
          if (cnt_q == PULSE_LAST) first_d = 1'b0;
          if (cnt_q >= per_last) cnt_d = '0;
          else                   cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        ph_d    = PH_OFF;
        cnt_d   = '0;
        first_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_OFF;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  assign load_en    = (ph_q == PH_RUN) && (cnt_q < PULSE_LEN);
  assign pulse_end  = (ph_q == PH_RUN) && pwr_ok && tick && (cnt_q == PULSE_LAST);
  assign first_test = first_q;

endmodule

// File: rtl/bts_sampler.sv
module bts_sampler
  import batt_test_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_ok,
  input  logic     load_en,
  input  logic     pulse_end,
  input  logic     bat_low,
  input  logic     bat_none,
  output reading_t reading
);

  logic low_q, low_d;
  logic none_q, none_d;
  logic low_now, none_now;

  assign low_now  = load_en & bat_low;
  assign none_now = load_en & bat_none;

  always_comb begin
    low_d  = low_q | low_now;
    none_d = none_q | none_now;
    if (!pwr_ok || pulse_end) begin
      low_d  = 1'b0;
      none_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 1'b0;
      none_q <= 1'b0;
    end else begin
      low_q  <= low_d;
      none_q <= none_d;
    end
  end

  always_comb begin
    if (none_q || none_now)    reading = RD_NONE;
    else if (low_q || low_now) reading = RD_LOW;
    else                       reading = RD_GOOD;
  end

endmodule

// File: rtl/bts_warn.sv
module bts_warn
  import batt_test_pkg::*;
#(
  parameter int ABSENT_TICKS = 700,
  parameter int AW           = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     pwr_ok,
  input  logic     pulse_end,
  input  logic     first_test,
  input  reading_t reading,
  output logic     warned,
  output logic     clear_ok
);

  localparam logic [AW-1:0] ABS_LAST = AW'(ABSENT_TICKS - 1);

  logic          warn_q, warn_d;
  logic          abs_q, abs_d;
  logic [AW-1:0] acnt_q, acnt_d;
  logic          abs_done;

  assign abs_done = (acnt_q == ABS_LAST);
  assign clear_ok = first_test | (abs_q & abs_done);

  always_comb begin
    warn_d = warn_q;
    abs_d  = abs_q;
    acnt_d = acnt_q;
    if (!pwr_ok) begin
      abs_d  = 1'b0;
      acnt_d = '0;
    end else begin
      if (abs_q && tick && !abs_done) acnt_d = acnt_q + 1'b1;
      if (pulse_end) begin
        case (reading)
          RD_NONE: begin
            warn_d = 1'b1;
            if (!abs_q) begin
              abs_d  = 1'b1;
              acnt_d = '0;
            end
          end
          RD_LOW: begin
            warn_d = 1'b1;
            abs_d  = 1'b0;
            acnt_d = '0;
          end
          default: begin
            warn_d = warn_q & ~clear_ok;
            abs_d  = 1'b0;
            acnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      abs_q  <= 1'b0;
      acnt_q <= '0;
    end else begin
      warn_q <= warn_d;
      abs_q  <= abs_d;
      acnt_q <= acnt_d;
    end
  end

  assign warned = warn_q;

endmodule

// File: rtl/batt_load_sched.sv
module batt_load_sched
  import batt_test_pkg::*;
#(
  parameter int REC_TICKS    = 5,
  parameter int PULSE_TICKS  = 100,
  parameter int NORM_TICKS   = 8640000,
  parameter int WARN_TICKS   = 500,
  parameter int ABSENT_TICKS = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_ok,
  input  logic bat_low,
  input  logic bat_none,
  output logic load_en,
  output logic warn_n
);

  localparam int CW = $clog2(NORM_TICKS + WARN_TICKS + REC_TICKS + 1);
  localparam int AW = $clog2(ABSENT_TICKS + 1);

  logic     warned;
  logic     pulse_end;
  logic     first_test;
  logic     clear_ok;
  reading_t reading;

  bts_timer #(
    .REC_TICKS  (REC_TICKS),
    .PULSE_TICKS(PULSE_TICKS),
    .NORM_TICKS (NORM_TICKS),
    .WARN_TICKS (WARN_TICKS),
    .CW         (CW)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pwr_ok    (pwr_ok),
    .warned    (warned),
    .load_en   (load_en),
    .pulse_end (pulse_end),
    .first_test(first_test)
  );

  bts_sampler sampler_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .load_en  (load_en),
    .pulse_end(pulse_end),
    .bat_low  (bat_low),
    .bat_none (bat_none),
    .reading  (reading)
  );

  bts_warn #(
    .ABSENT_TICKS(ABSENT_TICKS),
    .AW          (AW)
  ) warn_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pwr_ok    (pwr_ok),
    .pulse_end (pulse_end),
    .first_test(first_test),
    .reading   (reading),
    .warned    (warned),
    .clear_ok  (clear_ok)
  );

  assign warn_n = ~warned;

endmodule

// File: rtl/batt_load_sched_chk.sv
module batt_load_sched_chk
  import batt_test_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     pwr_ok,
  input logic     load_en,
  input logic     warn_n,
  input logic     clear_ok,
  input reading_t reading
);

  // R8
  no_load_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !load_en);

  // R2
  load_start_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_en) |-> $past(pwr_ok));

  // R5
  warn_edge_at_pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(warn_n) |-> ($past(load_en) && !load_en));

  // R5
  warn_set_needs_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_n) |-> $past(reading != RD_GOOD));

  // R7
  warn_clear_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_n) |-> $past(clear_ok && reading == RD_GOOD));

  // R8
  warn_held_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> $stable(warn_n));

endmodule

bind batt_load_sched batt_load_sched_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwr_ok  (pwr_ok),
  .load_en (load_en),
  .warn_n  (warn_n),
  .clear_ok(clear_ok),
  .reading (reading)
);

// File: tb/batt_load_sched_tb_top.sv
module batt_load_sched_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int REC   = 3;
  localparam int PULSE = 2;
  localparam int NORM  = 20;
  localparam int WARN  = 6;
  localparam int ABSN  = 12;

  logic clk, rst_n, tick, pwr_ok, bat_low, bat_none;
  logic load_en, warn_n;
  int   checks, errors;
  bit   done;

  batt_load_sched #(
    .REC_TICKS(REC), .PULSE_TICKS(PULSE), .NORM_TICKS(NORM),
    .WARN_TICKS(WARN), .ABSENT_TICKS(ABSN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok),
    .bat_low(bat_low), .bat_none(bat_none),
    .load_en(load_en), .warn_n(warn_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic exp_cleared(int n_missing);
    return (n_missing * WARN) >= ABSN;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  // warned and at pulse start on entry; warned and at pulse start on exit
  task automatic removal_trial(int n);
    logic exp;
    for (int k = 0; k < n; k++) begin
      bat_none = 1'b1;
      ticks(PULSE);
      bat_none = 1'b0;
      ticks(WARN - PULSE);
    end
    ticks(PULSE);
    exp = exp_cleared(n);
    chk("R7 replacement clear", warn_n, exp);
    if (exp) begin
      ticks(NORM - PULSE - 1);
      chk("R7 normal interval after clear (idle)", load_en, 1'b0);
      ticks(1);
      chk("R7 normal interval after clear", load_en, 1'b1);
      bat_low = 1'b1;
      ticks(PULSE);
      bat_low = 1'b0;
      chk("R5 rewarn", warn_n, 1'b0);
    end
    ticks(WARN - PULSE);
    chk("R6 warned interval", load_en, 1'b1);
  endtask

  initial begin
    int unused_seed;
    checks = 0; errors = 0; done = 1'b0;
    unused_seed = $urandom(32'd4711);
    rst_n = 1'b0; tick = 1'b0; pwr_ok = 1'b0; bat_low = 1'b0; bat_none = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset load", load_en, 1'b0);
    chk("R1 reset warn", warn_n, 1'b1);
    ticks(5);
    chk("R1 no load unpowered", load_en, 1'b0);

    // power-up and recovery
    pwr_ok = 1'b1;
    ticks(REC - 1);
    chk("R2 before recovery", load_en, 1'b0);
    ticks(1);
    chk("R2 first test", load_en, 1'b1);
    ticks(PULSE - 1);
    chk("R3 pulse held", load_en, 1'b1);
    ticks(1);
    chk("R3 pulse end", load_en, 1'b0);
    chk("R4 good battery no warn", warn_n, 1'b1);

    // comparator ignored while load is off
    bat_low = 1'b1; bat_none = 1'b1;
    ticks(NORM - PULSE - 1);
    chk("R5 ignored outside pulse", warn_n, 1'b1);
    chk("R4 idle before next test", load_en, 1'b0);
    bat_low = 1'b0; bat_none = 1'b0;
    ticks(1);
    chk("R4 normal interval", load_en, 1'b1);

    // single-clock low reading mid-pulse
    @(negedge clk) bat_low = 1'b1;
    @(negedge clk) bat_low = 1'b0;
    chk("R5 warn waits for pulse end", warn_n, 1'b1);
    ticks(PULSE);
    chk("R5 warn set", warn_n, 1'b0);
    ticks(WARN - PULSE - 1);
    chk("R6 idle before warned test", load_en, 1'b0);
    ticks(1);
    chk("R6 warned interval", load_en, 1'b1);

    // directed replacement boundaries
    removal_trial(1);
    removal_trial(2);

    // low reading inside an absence run restarts it
    bat_none = 1'b1; ticks(PULSE); bat_none = 1'b0; ticks(WARN - PULSE);
    bat_low = 1'b1;  ticks(PULSE); bat_low = 1'b0;  ticks(WARN - PULSE);
    ticks(PULSE);
    chk("R10 absence restarted by low reading", warn_n, 1'b0);
    ticks(WARN - PULSE);

    // seeded random replacement runs
    for (int t = 0; t < 5; t++) begin
      removal_trial(1 + int'($urandom % 3));
    end

    // power loss mid-pulse while warned
    chk("R8 at pulse start", load_en, 1'b1);
    @(negedge clk) pwr_ok = 1'b0;
    @(negedge clk);
    chk("R8 load drops", load_en, 1'b0);
    ticks(4);
    chk("R8 no load while off", load_en, 1'b0);
    chk("R8 warn held", warn_n, 1'b0);

    // power-up retest with good battery clears
    pwr_ok = 1'b1;
    ticks(REC);
    chk("R2 retest after power-up", load_en, 1'b1);
    ticks(PULSE);
    chk("R9 good first test clears", warn_n, 1'b1);
    ticks(NORM - PULSE);
    chk("R4 normal interval after power-up clear", load_en, 1'b1);

    // low reading in a discarded test
    bat_low = 1'b1;
    @(negedge clk) begin pwr_ok = 1'b0; bat_low = 1'b0; end
    @(negedge clk);
    chk("R8 discarded test no warn", warn_n, 1'b1);
    pwr_ok = 1'b1;
    ticks(REC + PULSE);
    chk("R8 discarded reading not applied", warn_n, 1'b1);

    // warned at power-down, still low at power-up
    ticks(NORM - PULSE);
    bat_low = 1'b1; ticks(PULSE); bat_low = 1'b0;
    chk("R5 warn set again", warn_n, 1'b0);
    @(negedge clk) pwr_ok = 1'b0;
    ticks(2);
    pwr_ok = 1'b1;
    ticks(REC);
    bat_low = 1'b1; ticks(PULSE); bat_low = 1'b0;
    chk("R9 low first test keeps warn", warn_n, 1'b0);
    ticks(WARN - PULSE);
    chk("R6 warned interval after power-up", load_en, 1'b1);

    finish_run();
  end

endmodule